// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block watches host bus cycles and drives two active-low, general-purpose chip selects. Each chip select has its own IO window and its own memory window, and each window has its own enable. A window is a base plus a mask of don't-care bits. When a valid cycle lands in an enabled window, the block pulls that chip select low and raises a claim flag. The claim flag tells the bus controller to take the cycle and forward it to the legacy expansion bus.

An IO window compares a 16-bit address. A per-bit mask can exclude any of the low eight bits. A single extra control bit can also exclude bits 10:8. Bits 15:11 always take part in the compare. A memory window compares the full 32-bit address against its base on every bit its mask leaves clear.

Every decode depends on a pin-function code. A chip select can only assert when its shared pin is set to the chip-select role.

The decode is purely combinational. Each cycle is presented with a plain valid strobe and is never stalled, so the block has no back-pressure. The outputs settle in the same cycle the inputs are applied.

Top module: `pnp_csel_decode`

## Requirements
- R1: While `cyc_valid` is 0, every bit of `cs_n` is 1 and `claim` is 0, whatever the address and configuration.
- R2: A valid IO cycle (`cyc_is_io`=1) asserts `cs_n[i]` low when all of the following hold: lane i has its IO enable set, its pin code is 2'b01, and `cyc_addr[15:0]` equals its IO base on every compared bit. Differing in any single compared bit is a miss.
- R3: IO fine-mask bit k (k = 0..7), when 1, makes IO address bit k a don't-care for that lane. When it is 0, bit k must match.
- R4: When a lane's upper-mask control is 1, IO address bits 10:8 are excluded from the compare. When it is 0, they must match. Bits 15:11 are always compared.
- R5: A valid memory cycle (`cyc_is_io`=0) asserts `cs_n[i]` low when lane i has its memory enable set, its pin code is 2'b01, and `(cyc_addr ^ mem_base) & ~mem_mask` is zero over all 32 bits. A mask bit of 1 is a don't-care.
- R6: An IO enable alone never causes a hit on a memory cycle, and a memory enable alone never causes a hit on an IO cycle.
- R7: If a lane's pin code is anything other than 2'b01, that lane's `cs_n` stays 1 and it adds nothing to `claim`. This holds even when its enables are set and the address matches. The other codes are 2'b00 (plain interrupt), 2'b10 (alert input) and 2'b11 (over-current input).
- R8: `claim` is 1 exactly when at least one `cs_n` bit is 0. When both lanes match the same cycle, both chip selects assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cyc_valid | input | 1 | A host cycle is present this clock |
| cyc_is_io | input | 1 | 1 = IO cycle, 0 = memory cycle |
| cyc_addr | input | 32 | Cycle address; an IO cycle uses bits 15:0 |
| cfg_pin_fn | input | 4 | 2-bit pin-function code per lane; 2'b01 = chip select |
| cfg_io_en | input | 2 | IO window enable per lane |
| cfg_mem_en | input | 2 | Memory window enable per lane |
| cfg_io_base | input | 32 | 16-bit IO base per lane |
| cfg_io_fine_mask | input | 16 | 8-bit low don't-care mask per lane |
| cfg_io_upper_mask | input | 2 | Per lane: 1 = ignore IO bits 10:8 |
| cfg_mem_base | input | 64 | 32-bit memory base per lane |
| cfg_mem_mask | input | 64 | 32-bit memory don't-care mask per lane |
| cs_n | output | 2 | Active-low chip selects |
| claim | output | 1 | Cycle should be claimed and forwarded |

## Verification
The bench uses single-bit address perturbations against exact bases. This separates a correct compare from one that drops or inverts a bit. The tests exercise the low mask, the upper-mask control and the always-compared bits 15:11, which shows that each mask reaches only its own bits. Cycles of the opposite type, and every pin code other than the chip-select role, show that the type and role gates each block a hit on their own. Overlapping windows on both lanes, compared with a hit on a single lane, tell a proper OR claim apart from one tied to a single lane.

// File: rtl/pnp_csel_pkg.sv
package pnp_csel_pkg;
  // Function assigned to a shared pin.
  typedef enum logic [1:0] {
    PF_IRQ      = 2'b00,
    PF_CSEL     = 2'b01,
    PF_ALERT    = 2'b10,
    PF_OVERCUR  = 2'b11
  } pin_fn_e;

  localparam int unsigned PIN_FN_W = 2;
endpackage

// File: rtl/io_window_match.sv
module io_window_match #(
  parameter int unsigned IO_AW   = 16,
  parameter int unsigned FINE_W  = 8,
  parameter int unsigned UP_LO   = 8,
  parameter int unsigned UP_HI   = 10
) (
  input  logic [IO_AW-1:0]  addr,
  input  logic [IO_AW-1:0]  base,
  input  logic [FINE_W-1:0] fine_mask,
  input  logic              upper_mask,
  output logic              hit
);
  logic [IO_AW-1:0] dont_care;
  logic [IO_AW-1:0] diff;

  // Build the don't-care vector bit by bit.
  for (genvar b = 0; b < IO_AW; b++) begin : g_bit
    if (b < FINE_W) begin : g_fine
      assign dont_care[b] = fine_mask[b];
    end else if (b >= UP_LO && b <= UP_HI) begin : g_upper
      assign dont_care[b] = upper_mask;
    end else begin : g_fixed
      assign dont_care[b] = 1'b0;
    end
  end

  assign diff = (addr ^ base) & ~dont_care;
  assign hit  = (diff == '0);
endmodule

// File: rtl/mem_window_match.sv
module mem_window_match #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  output logic          hit
);
  logic [AW-1:0] diff;
  assign diff = (addr ^ base) & ~mask;
  assign hit  = (diff == '0);
endmodule

// File: rtl/csel_lane.sv
module csel_lane
  import pnp_csel_pkg::*;
#(
  parameter int unsigned MEM_AW = 32,
  parameter int unsigned IO_AW  = 16,
  parameter int unsigned FINE_W = 8
) (
  input  logic                cyc_valid,
  input  logic                cyc_is_io,
  input  logic [MEM_AW-1:0]   cyc_addr,
  input  logic [PIN_FN_W-1:0] pin_fn,
  input  logic                io_en,
  input  logic                mem_en,
  input  logic [IO_AW-1:0]    io_base,
  input  logic [FINE_W-1:0]   io_fine_mask,
  input  logic                io_upper_mask,
  input  logic [MEM_AW-1:0]   mem_base,
  input  logic [MEM_AW-1:0]   mem_mask,
  output logic                hit
);
  logic io_match;
  logic mem_match;
  logic role_ok;
  logic io_hit;
  logic mem_hit;

  io_window_match #(
    .IO_AW (IO_AW),
    .FINE_W(FINE_W),
    .UP_LO (8),
    .UP_HI (10)
  ) u_io (
    .addr      (cyc_addr[IO_AW-1:0]),
    .base      (io_base),
    .fine_mask (io_fine_mask),
    .upper_mask(io_upper_mask),
    .hit       (io_match)
  );

  mem_window_match #(.AW(MEM_AW)) u_mem (
    .addr(cyc_addr),
    .base(mem_base),
    .mask(mem_mask),
    .hit (mem_match)
  );

  assign role_ok = (pin_fn == PF_CSEL);
  assign io_hit  = cyc_is_io  & io_en  & io_match;
  assign mem_hit = ~cyc_is_io & mem_en & mem_match;
  assign hit     = cyc_valid & role_ok & (io_hit | mem_hit);
endmodule

// File: rtl/pnp_csel_decode.sv
module pnp_csel_decode
  import pnp_csel_pkg::*;
#(
  parameter int unsigned NUM_CS = 2,
  parameter int unsigned MEM_AW = 32,
  parameter int unsigned IO_AW  = 16,
  parameter int unsigned FINE_W = 8
) (
  input  logic                         cyc_valid,
  input  logic                         cyc_is_io,
  input  logic [MEM_AW-1:0]            cyc_addr,
  input  logic [NUM_CS*PIN_FN_W-1:0]   cfg_pin_fn,
  input  logic [NUM_CS-1:0]            cfg_io_en,
  input  logic [NUM_CS-1:0]            cfg_mem_en,
  input  logic [NUM_CS*IO_AW-1:0]      cfg_io_base,
  input  logic [NUM_CS*FINE_W-1:0]     cfg_io_fine_mask,
  input  logic [NUM_CS-1:0]            cfg_io_upper_mask,
  input  logic [NUM_CS*MEM_AW-1:0]     cfg_mem_base,
  input  logic [NUM_CS*MEM_AW-1:0]     cfg_mem_mask,
  output logic [NUM_CS-1:0]            cs_n,
  output logic                         claim
);
  logic [NUM_CS-1:0] lane_hit;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_lane
    csel_lane #(
      .MEM_AW(MEM_AW),
      .IO_AW (IO_AW),
      .FINE_W(FINE_W)
    ) u_lane (
      .cyc_valid    (cyc_valid),
      .cyc_is_io    (cyc_is_io),
      .cyc_addr     (cyc_addr),
      .pin_fn       (cfg_pin_fn[i*PIN_FN_W +: PIN_FN_W]),
      .io_en        (cfg_io_en[i]),
      .mem_en       (cfg_mem_en[i]),
      .io_base      (cfg_io_base[i*IO_AW +: IO_AW]),
      .io_fine_mask (cfg_io_fine_mask[i*FINE_W +: FINE_W]),
      .io_upper_mask(cfg_io_upper_mask[i]),
      .mem_base     (cfg_mem_base[i*MEM_AW +: MEM_AW]),
      .mem_mask     (cfg_mem_mask[i*MEM_AW +: MEM_AW]),
      .hit          (lane_hit[i])
    );
  end

  assign cs_n  = ~lane_hit;
  assign claim = |lane_hit;
endmodule

// File: rtl/pnp_csel_checker.sv
module pnp_csel_checker
  import pnp_csel_pkg::*;
#(
  parameter int unsigned NUM_CS = 2,
  parameter int unsigned MEM_AW = 32
) (
  input logic                       cyc_valid,
  input logic                       cyc_is_io,
  input logic [MEM_AW-1:0]          cyc_addr,
  input logic [NUM_CS*PIN_FN_W-1:0] cfg_pin_fn,
  input logic [NUM_CS-1:0]          cfg_io_en,
  input logic [NUM_CS-1:0]          cfg_mem_en,
  input logic [NUM_CS*MEM_AW-1:0]   cfg_mem_base,
  input logic [NUM_CS*MEM_AW-1:0]   cfg_mem_mask,
  input logic [NUM_CS-1:0]          cs_n,
  input logic                       claim
);
  always_comb begin
    if (!cyc_valid) begin
      p_idle_quiet_r1: assert ((&cs_n) && !claim);
    end
    p_claim_any_r8: assert (claim == (~cs_n != '0));
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_chk
    always_comb begin
      if (cfg_pin_fn[i*PIN_FN_W +: PIN_FN_W] != PF_CSEL) begin
        p_role_gate_r7: assert (cs_n[i]);
      end
      if (!cs_n[i]) begin
        p_type_enable_r6: assert (cyc_is_io ? cfg_io_en[i] : cfg_mem_en[i]);
      end
      if (!cs_n[i] && !cyc_is_io) begin
        p_mem_inside_r5: assert (((cyc_addr ^ cfg_mem_base[i*MEM_AW +: MEM_AW])
                                  & ~cfg_mem_mask[i*MEM_AW +: MEM_AW]) == '0);
      end
    end
  end
endmodule

bind pnp_csel_decode pnp_csel_checker #(
  .NUM_CS(NUM_CS),
  .MEM_AW(MEM_AW)
) u_chk (
  .cyc_valid   (cyc_valid),
  .cyc_is_io   (cyc_is_io),
  .cyc_addr    (cyc_addr),
  .cfg_pin_fn  (cfg_pin_fn),
  .cfg_io_en   (cfg_io_en),
  .cfg_mem_en  (cfg_mem_en),
  .cfg_mem_base(cfg_mem_base),
  .cfg_mem_mask(cfg_mem_mask),
  .cs_n        (cs_n),
  .claim       (claim)
);

// File: tb/sim_pnp_csel_decode.sv
module sim_pnp_csel_decode;
  logic        clk = 1'b0;
  logic        cyc_valid;
  logic        cyc_is_io;
  logic [31:0] cyc_addr;
  logic [3:0]  cfg_pin_fn;
  logic [1:0]  cfg_io_en;
  logic [1:0]  cfg_mem_en;
  logic [31:0] cfg_io_base;
  logic [15:0] cfg_io_fine_mask;
  logic [1:0]  cfg_io_upper_mask;
  logic [63:0] cfg_mem_base;
  logic [63:0] cfg_mem_mask;
  logic [1:0]  cs_n;
  logic        claim;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pnp_csel_decode u0 (
    .cyc_valid        (cyc_valid),
    .cyc_is_io        (cyc_is_io),
    .cyc_addr         (cyc_addr),
    .cfg_pin_fn       (cfg_pin_fn),
    .cfg_io_en        (cfg_io_en),
    .cfg_mem_en       (cfg_mem_en),
    .cfg_io_base      (cfg_io_base),
    .cfg_io_fine_mask (cfg_io_fine_mask),
    .cfg_io_upper_mask(cfg_io_upper_mask),
    .cfg_mem_base     (cfg_mem_base),
    .cfg_mem_mask     (cfg_mem_mask),
    .cs_n             (cs_n),
    .claim            (claim)
  );

  task automatic clear_cfg();
    cfg_pin_fn        = 4'b0101;
    cfg_io_en         = '0;
    cfg_mem_en        = '0;
    cfg_io_base       = '0;
    cfg_io_fine_mask  = '0;
    cfg_io_upper_mask = '0;
    cfg_mem_base      = '0;
    cfg_mem_mask      = '0;
  endtask

  task automatic set_io(int lane, logic [15:0] base, logic [7:0] fine, logic up);
    cfg_io_en[lane]              = 1'b1;
    cfg_io_base[lane*16 +: 16]   = base;
    cfg_io_fine_mask[lane*8 +: 8] = fine;
    cfg_io_upper_mask[lane]      = up;
  endtask

  task automatic set_mem(int lane, logic [31:0] base, logic [31:0] mask);
    cfg_mem_en[lane]           = 1'b1;
    cfg_mem_base[lane*32 +: 32] = base;
    cfg_mem_mask[lane*32 +: 32] = mask;
  endtask

  // Apply a cycle away from the edge, then sample after settling.
  task automatic apply(logic v, logic io, logic [31:0] a,
                       logic [1:0] exp_cs, logic exp_claim, string req);
    @(negedge clk);
    cyc_valid = v;
    cyc_is_io = io;
    cyc_addr  = a;
    #2;
    checks++;
    if (cs_n !== exp_cs || claim !== exp_claim) begin
      errors++;
      $display("FAIL %s addr=%h io=%0b: cs_n=%b claim=%b expected cs_n=%b claim=%b",
               req, a, io, cs_n, claim, exp_cs, exp_claim);
    end
  endtask

  task automatic t_idle_r1();
    clear_cfg();
    set_io(0, 16'h0320, 8'h00, 1'b0);
    set_io(1, 16'h0320, 8'h00, 1'b0);
    apply(1'b0, 1'b1, 32'h0000_0320, 2'b11, 1'b0, "R1");
    apply(1'b0, 1'b0, 32'h0000_0320, 2'b11, 1'b0, "R1");
  endtask

  task automatic t_io_exact_r2();
    clear_cfg();
    set_io(0, 16'h0320, 8'h00, 1'b0);
    apply(1'b1, 1'b1, 32'h0000_0320, 2'b10, 1'b1, "R2");
    apply(1'b1, 1'b1, 32'h0000_0321, 2'b11, 1'b0, "R2");
    apply(1'b1, 1'b1, 32'h0000_8320, 2'b11, 1'b0, "R2");
  endtask

  task automatic t_fine_mask_r3();
    clear_cfg();
    set_io(0, 16'h0320, 8'h07, 1'b0);
    apply(1'b1, 1'b1, 32'h0000_0327, 2'b10, 1'b1, "R3");
    apply(1'b1, 1'b1, 32'h0000_0328, 2'b11, 1'b0, "R3");
  endtask

  task automatic t_upper_mask_r4();
    clear_cfg();
    set_io(0, 16'h0320, 8'h00, 1'b1);
    apply(1'b1, 1'b1, 32'h0000_0520, 2'b10, 1'b1, "R4");
    apply(1'b1, 1'b1, 32'h0000_0B20, 2'b11, 1'b0, "R4");
    cfg_io_upper_mask[0] = 1'b0;
    apply(1'b1, 1'b1, 32'h0000_0520, 2'b11, 1'b0, "R4");
  endtask

  task automatic t_mem_r5();
    clear_cfg();
    set_mem(1, 32'h000D_0000, 32'h0000_FFFF);
    apply(1'b1, 1'b0, 32'h000D_ABCD, 2'b01, 1'b1, "R5");
    apply(1'b1, 1'b0, 32'h000E_0000, 2'b11, 1'b0, "R5");
    apply(1'b1, 1'b0, 32'h800D_0000, 2'b11, 1'b0, "R5");
  endtask

  task automatic t_type_r6();
    clear_cfg();
    set_io(0, 16'h0320, 8'h00, 1'b0);
    set_mem(1, 32'h0000_D000, 32'h0000_0FFF);
    apply(1'b1, 1'b0, 32'h0000_0320, 2'b11, 1'b0, "R6");
    apply(1'b1, 1'b1, 32'h0000_D000, 2'b11, 1'b0, "R6");
  endtask

  task automatic t_role_r7();
    clear_cfg();
    set_io(0, 16'h0320, 8'h00, 1'b0);
    for (int code = 0; code < 4; code++) begin
      cfg_pin_fn[1:0] = 2'(code);
      if (code == 1)
        apply(1'b1, 1'b1, 32'h0000_0320, 2'b10, 1'b1, "R7");
      else
        apply(1'b1, 1'b1, 32'h0000_0320, 2'b11, 1'b0, "R7");
    end
  endtask

  task automatic t_both_r8();
    clear_cfg();
    set_io(0, 16'h0320, 8'h00, 1'b0);
    set_io(1, 16'h0320, 8'h0F, 1'b0);
    apply(1'b1, 1'b1, 32'h0000_0320, 2'b00, 1'b1, "R8");
    apply(1'b1, 1'b1, 32'h0000_032A, 2'b01, 1'b1, "R8");
  endtask

  initial begin
    clear_cfg();
    cyc_valid = 1'b0;
    cyc_is_io = 1'b0;
    cyc_addr  = '0;
    repeat (3) @(posedge clk);
    t_idle_r1();
    t_io_exact_r2();
    t_fine_mask_r3();
    t_upper_mask_r4();
    t_mem_r5();
    t_type_r6();
    t_role_r7();
    t_both_r8();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule